// File: doc/BRIEF.md
# Configurable Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. A single synchronous clock runs it, and a one-cycle strobe at sixteen times the bit rate paces it. The block detects a start condition and confirms it at the middle of the start bit. It then samples every data bit and the optional parity bit at the middle of the bit, and it checks the first stop bit. The finished character moves into a holding register that is separate from the shift register. The host can therefore read one character while the next one arrives.

The character length can be set from five to eight bits. The first bit received lands in bit 0, and any unused upper bits read as zero. Parity can be turned off, set to even or odd, or forced to a fixed value (stick parity). Status outputs report a waiting character, a parity mismatch, a bad stop bit and a lost character. The status clears when the host pulses its read strobe. The bit-rate strobe comes from outside the block. Configuration is expected to stay unchanged while a character is being received.

Top module: `serial_char_rx`

## Requirements
- R1: `cfg_len` selects the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. The character is right-justified in `rx_data`, and every bit above the selected length reads as 0.
- R2: The first serial bit after the start bit is stored in `rx_data[0]`. Each later bit goes into the next higher position.
- R3: When `cfg_par_en` is 1 and `cfg_stick` is 0, one parity bit follows the data. With `cfg_even` = 1 the data bits plus the parity bit must hold an even number of ones; with `cfg_even` = 0 they must hold an odd number. A mismatch sets `parity_err`. When `cfg_par_en` is 0, no parity bit is expected and `parity_err` stays 0.
- R4: When `cfg_par_en` and `cfg_stick` are both 1, the expected parity bit is the inverse of `cfg_even`. A received parity bit of any other value sets `parity_err`.
- R5: `rx_data` keeps the previous character while the next one is shifted in. It changes only when a completed character is transferred.
- R6: A falling edge on the line is taken as a start bit only if the line is still low 8 ticks later. Otherwise the receiver goes back to idle and delivers no character.
- R7: If the line is low at the first stop-bit sample, `framing_err` is set together with the transfer of the character.
- R8: `data_ready` goes to 1 when a character is transferred and goes to 0 on `rd_strobe`. If a transfer happens in the same cycle as a read, `data_ready` stays 1.
- R9: If a character completes while `data_ready` is 1 and no read happens in that cycle, the new character overwrites `rx_data` and `overrun` is set.
- R10: `rd_strobe` clears `parity_err`, `framing_err` and `overrun`. Only a read clears `overrun`.
- R11: After reset, `data_ready`, `parity_err`, `framing_err` and `overrun` are 0 and `rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_16x | input | 1 | One-cycle strobe at 16 times the bit rate |
| serial_in | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | 2 | Character length code (5 to 8 bits) |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_even | input | 1 | Even parity select |
| cfg_stick | input | 1 | Forced parity value select |
| rd_strobe | input | 1 | Host read of the holding register |
| rx_data | output | 8 | Received character, right-justified |
| data_ready | output | 1 | Unread character waiting |
| parity_err | output | 1 | Parity mismatch on the held character |
| framing_err | output | 1 | Low stop bit on the held character |
| overrun | output | 1 | A character was overwritten before it was read |

## Verification
The bench covers these corner cases:
- **Short characters.** Five-bit characters are sent with the upper line bits set. A receiver that does not mask by length would show stray high bits.
- **Stick parity.** Each stick setting is tried with both received parity values. A receiver that computes real parity here would flag the wrong characters.
- **Short glitch.** A low pulse shorter than half a bit must produce no character. A receiver that skips the mid-start check would deliver garbage.
- **Back-to-back characters without a read.** These show whether the held character survives while the next one shifts in, and whether the overwrite raises `overrun`.
- **Randomized configurations.** Random settings, data and parity faults test the bit order and the even and odd rules across all lengths.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int MAX_BITS = 8;
    localparam int MIN_BITS = 5;
    localparam int IDX_W    = $clog2(MAX_BITS);

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       even;
        logic       stick;
    } rx_cfg_t;

    typedef struct packed {
        logic [MAX_BITS-1:0] data;
        logic                par_err;
        logic                frm_err;
    } rx_char_t;

    // Index of the last data bit for a length code
    function automatic logic [IDX_W-1:0] last_index(input logic [1:0] len);
        return IDX_W'(MIN_BITS - 1) + IDX_W'(len);
    endfunction

    // Parity bit the sender should have put on the line
    function automatic logic wanted_parity(input logic [MAX_BITS-1:0] data,
                                           input rx_cfg_t cfg);
        if (cfg.stick)
            return ~cfg.even;
        return cfg.even ? ^data : ~^data;
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '1;
        else
            chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
    import serial_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     rxd,
    input  rx_cfg_t  cfg,
    output logic     load,
    output rx_char_t char_out
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVERSAMPLE - 1);

    rx_state_e           state;
    logic [CNT_W-1:0]    cnt;
    logic [IDX_W-1:0]    idx;
    logic [MAX_BITS-1:0] shf;
    logic                par_bad;
    logic                bit_mid;

    assign bit_mid = (cnt == FULL_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_IDLE;
            cnt      <= '0;
            idx      <= '0;
            shf      <= '0;
            par_bad  <= 1'b0;
            load     <= 1'b0;
            char_out <= '0;
        end else begin
            load <= 1'b0;
            if (tick) begin
                unique case (state)
                    RX_IDLE: begin
                        if (!rxd) begin
                            state <= RX_START;
                            cnt   <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt == HALF_LAST) begin
                            cnt <= '0;
                            if (!rxd) begin
                                state   <= RX_DATA;
                                idx     <= '0;
                                shf     <= '0;
                                par_bad <= 1'b0;
                            end else begin
                                state <= RX_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (bit_mid) begin
                            cnt      <= '0;
                            shf[idx] <= rxd;
                            if (idx == last_index(cfg.len))
                                state <= cfg.par_en ? RX_PARITY : RX_STOP;
                            else
                                idx <= idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_PARITY: begin
                        if (bit_mid) begin
                            cnt     <= '0;
                            par_bad <= (rxd != wanted_parity(shf, cfg));
                            state   <= RX_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (bit_mid) begin
                            cnt              <= '0;
                            char_out.data    <= shf;
                            char_out.par_err <= cfg.par_en & par_bad;
                            char_out.frm_err <= ~rxd;
                            load             <= 1'b1;
                            state            <= RX_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_hold_reg.sv
module rx_hold_reg
    import serial_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  rx_char_t            char_in,
    input  logic                rd,
    output logic [MAX_BITS-1:0] data,
    output logic                ready,
    output logic                pe,
    output logic                fe,
    output logic                ovr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data  <= '0;
            ready <= 1'b0;
            pe    <= 1'b0;
            fe    <= 1'b0;
            ovr   <= 1'b0;
        end else if (load) begin
            data  <= char_in.data;
            ready <= 1'b1;
            pe    <= char_in.par_err;
            fe    <= char_in.frm_err;
            ovr   <= rd ? 1'b0 : (ovr | ready);
        end else if (rd) begin
            ready <= 1'b0;
            pe    <= 1'b0;
            fe    <= 1'b0;
            ovr   <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx
    import serial_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_16x,
    input  logic                serial_in,
    input  logic [1:0]          cfg_len,
    input  logic                cfg_par_en,
    input  logic                cfg_even,
    input  logic                cfg_stick,
    input  logic                rd_strobe,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                data_ready,
    output logic                parity_err,
    output logic                framing_err,
    output logic                overrun
);
    logic     rxd_s;
    logic     load;
    rx_char_t done_char;
    rx_cfg_t  cfg;

    assign cfg = '{len: cfg_len, par_en: cfg_par_en, even: cfg_even, stick: cfg_stick};

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (serial_in),
        .dout (rxd_s)
    );

    rx_frame_engine #(.OVERSAMPLE(OVERSAMPLE)) u_frame (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_16x),
        .rxd      (rxd_s),
        .cfg      (cfg),
        .load     (load),
        .char_out (done_char)
    );

    rx_hold_reg u_hold (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .char_in (done_char),
        .rd      (rd_strobe),
        .data    (rx_data),
        .ready   (data_ready),
        .pe      (parity_err),
        .fe      (framing_err),
        .ovr     (overrun)
    );
endmodule

// File: rtl/serial_char_rx_chk.sv
module serial_char_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       rd_strobe,
    input logic       cfg_par_en,
    input logic [1:0] cfg_len,
    input logic [7:0] rx_data,
    input logic       data_ready,
    input logic       parity_err,
    input logic       framing_err,
    input logic       overrun
);
    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(data_ready) |-> ((rx_data >> (4'd5 + {2'b00, $past(cfg_len)})) == 8'd0));

    assert_no_par_err_when_off_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(parity_err) |-> $past(cfg_par_en));

    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_data) |-> data_ready);

    assert_ready_falls_on_read_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(data_ready) |-> $past(rd_strobe));

    assert_overrun_needs_ready_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(data_ready));

    assert_overrun_clears_on_read_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(overrun) |-> $past(rd_strobe));

    assert_reset_state_R11: assert property (@(posedge clk)
        rst |=> (!data_ready && !overrun && !parity_err && !framing_err));
endmodule

bind serial_char_rx serial_char_rx_chk u_chk (.*);

// File: tb/serial_char_rx_tb.sv
module serial_char_rx_tb;
    localparam int TICK_DIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_16x = 1'b0;
    logic       serial_in = 1'b1;
    logic [1:0] cfg_len = 2'b11;
    logic       cfg_par_en = 1'b0;
    logic       cfg_even = 1'b0;
    logic       cfg_stick = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       data_ready, parity_err, framing_err, overrun;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int tdiv = 0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        tdiv     <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        tick_16x <= (tdiv == TICK_DIV - 1);
    end

    serial_char_rx u_dut (
        .clk(clk), .rst(rst), .tick_16x(tick_16x), .serial_in(serial_in),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_even(cfg_even),
        .cfg_stick(cfg_stick), .rd_strobe(rd_strobe), .rx_data(rx_data),
        .data_ready(data_ready), .parity_err(parity_err),
        .framing_err(framing_err), .overrun(overrun)
    );

    function automatic logic [7:0] mask_len(input logic [7:0] d, input logic [1:0] len);
        return d & ((8'd1 << (5 + len)) - 8'd1);
    endfunction

    function automatic logic par_bit(input logic [7:0] dm, input logic even, input logic stick);
        if (stick) return ~even;
        return even ? ^dm : ~^dm;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        int k = 0;
        while (k < n) begin
            @(negedge clk);
            if (tick_16x) k++;
        end
    endtask

    task automatic drive_bit(input logic b, input int n);
        serial_in = b;
        wait_ticks(n);
    endtask

    task automatic send_body(input logic [7:0] d, input logic [1:0] len,
                             input logic pen, input logic pbit);
        drive_bit(1'b0, 16);
        for (int i = 0; i < 5 + len; i++) drive_bit(d[i], 16);
        if (pen) drive_bit(pbit, 16);
    endtask

    task automatic send_stop(input bit good);
        if (good) drive_bit(1'b1, 16);
        else begin
            drive_bit(1'b0, 10);
            drive_bit(1'b1, 22);
        end
        drive_bit(1'b1, 4);
    endtask

    task automatic send_char(input logic [7:0] d, input bit flip_par, input bit good_stop);
        logic pb;
        pb = par_bit(mask_len(d, cfg_len), cfg_even, cfg_stick) ^ flip_par;
        send_body(d, cfg_len, cfg_par_en, pb);
        send_stop(good_stop);
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 ready", data_ready, 0);
        check("R11 data", rx_data, 0);
        check("R11 flags", {parity_err, framing_err, overrun}, 0);
        drive_bit(1'b1, 4);

        // R2 bit order, 8 bits, no parity
        cfg_len = 2'b11; cfg_par_en = 0;
        send_char(8'hA5 ^ 8'h01, 0, 1);
        check("R2 data", rx_data, 8'hA4);
        check("R8 ready set", data_ready, 1);
        check("R3 no parity err when off", parity_err, 0);
        do_read();
        check("R8 ready cleared", data_ready, 0);

        // R1 five bits, upper line bits set
        cfg_len = 2'b00;
        send_char(8'hF6, 0, 1);
        check("R1 five bit data", rx_data, 8'h16);
        do_read();

        // R3 odd parity good and bad
        cfg_len = 2'b10; cfg_par_en = 1; cfg_even = 0; cfg_stick = 0;
        send_char(8'h35, 0, 1);
        check("R3 odd good", {parity_err, rx_data}, {1'b0, 8'h35});
        do_read();
        send_char(8'h35, 1, 1);
        check("R3 odd bad", parity_err, 1);
        do_read();
        check("R10 parity cleared", parity_err, 0);

        // R4 stick parity, both settings and both line values
        cfg_len = 2'b01; cfg_stick = 1;
        for (int e = 0; e < 2; e++) begin
            for (int v = 0; v < 2; v++) begin
                cfg_even = e[0];
                send_body(8'h2B, cfg_len, 1'b1, v[0]);
                send_stop(1);
                check("R4 stick", parity_err, (v[0] == ~e[0]) ? 0 : 1);
                do_read();
            end
        end
        cfg_stick = 0; cfg_par_en = 0;

        // R7 framing error, R10 clear
        cfg_len = 2'b11;
        send_char(8'h5A, 0, 0);
        check("R7 framing", {framing_err, rx_data}, {1'b1, 8'h5A});
        do_read();
        check("R10 framing cleared", framing_err, 0);
        check("R6 no stray char after bad stop", data_ready, 0);

        // R6 short glitch
        drive_bit(1'b0, 4);
        drive_bit(1'b1, 40);
        check("R6 glitch rejected", data_ready, 0);

        // R5 and R9 back to back without read
        send_char(8'h11, 0, 1);
        send_body(8'hEE, cfg_len, 1'b0, 1'b0);
        check("R5 held during shift", {data_ready, rx_data}, {1'b1, 8'h11});
        send_stop(1);
        check("R9 overwrite", rx_data, 8'hEE);
        check("R9 overrun set", overrun, 1);
        do_read();
        check("R10 overrun cleared", {data_ready, overrun}, 0);

        // Random mix
        for (int n = 0; n < 30; n++) begin
            logic [7:0] d;
            bit flip;
            d          = 8'($urandom);
            cfg_len    = 2'($urandom);
            cfg_par_en = 1'($urandom);
            cfg_even   = 1'($urandom);
            cfg_stick  = 1'($urandom);
            flip       = cfg_par_en && ($urandom % 3 == 0);
            send_char(d, flip, 1);
            check("R1 R2 random data", rx_data, mask_len(d, cfg_len));
            check("R3 R4 random parity", parity_err, flip);
            check("R7 random frame ok", {data_ready, framing_err, overrun}, 3'b100);
            do_read();
        end
        finish_run();
    end
endmodule